// File: doc/BRIEF.md
# Machine-Cycle State Sequencer

This block decides, one machine cycle at a time, what a small 8-bit processor with 16-bit addressing does next. It can fetch an opcode, execute it, carry out a DMA transfer, or acknowledge an interrupt. Each machine cycle lasts a fixed number of clocks. An internal phase counter produces two one-clock timing strobes, an early one and a late one. On the clock that carries the late strobe, the sequencer captures the DMA-inbound, DMA-outbound and interrupt request lines. At the end of the cycle it chooses the next state from those captured values.

The sequencer holds the two 4-bit designators (the index pointer and the program-counter pointer), the 8-bit save register and the interrupt-enable flag. It applies the side effects of interrupt entry itself. During a DMA cycle it tells the register file to take the memory address from register 0 and to bump that register by one. It also shows which way the data moves.

Top module: `mseq_sequencer`

## Requirements
- R1: While reset is high and just after it is released, `sc` is 00 (fetch), `ie_q` is 1, and `x_q`, `p_q` and `t_q` are 0.
- R2: A machine cycle is CYC_LEN clocks long (8 by default). `tpa` is high for one clock at phase TPA_PH (1) and `tpb` is high for one clock at phase TPB_PH (5). `sc` changes only at a cycle boundary, so it is steady while `tpa` is high.
- R3: The state code is `sc` = 00 for fetch, 01 for execute, 10 for DMA and 11 for interrupt. A fetch cycle is always followed by an execute cycle.
- R4: If `exec_done` is low at the end of an execute cycle, another execute cycle follows. If it is high, the next state is chosen from the captured requests, or fetch when none is captured.
- R5: A request counts only if it is high during the clock on which `tpb` is high. A pulse that misses that clock has no effect.
- R6: When requests are captured together, DMA-inbound comes first, then DMA-outbound, then interrupt.
- R7: A DMA cycle never directly follows a fetch cycle. A pending DMA waits until an execute cycle ends with `exec_done` high.
- R8: In a DMA cycle, `addr_sel_r0` is 1. `dma_wr` is 1 for an inbound transfer (memory is written) and `dma_rd` is 1 for an outbound one. `ptr_inc` pulses exactly once, on the last clock of each DMA cycle.
- R9: If a DMA request is still captured at the end of a DMA cycle, another DMA cycle follows at once.
- R10: An interrupt cycle lasts one machine cycle. When it ends, `t_q` = {old X, old P} (X in bits 7:4), X = 2, P = 1 and `ie_q` = 0, and this overrides a designator write made in the same clock.
- R11: An interrupt is taken only while `ie_q` is 1. DMA requests are honoured whatever the value of `ie_q`. `ie_wr_en` writes `ie_wr_val` into the flag, and `xp_wr_en` loads `x_wr` and `p_wr`.
- R12: An interrupt cycle is never followed directly by another interrupt cycle. After it comes DMA if a DMA request is captured, and fetch otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_in_req | input | 1 | DMA request, peripheral to memory |
| dma_out_req | input | 1 | DMA request, memory to peripheral |
| irq_req | input | 1 | Interrupt request |
| exec_done | input | 1 | High when the current instruction finishes in this execute cycle |
| xp_wr_en | input | 1 | Load the designators from `x_wr` and `p_wr` |
| x_wr | input | 4 | New X designator |
| p_wr | input | 4 | New P designator |
| ie_wr_en | input | 1 | Load the interrupt-enable flag |
| ie_wr_val | input | 1 | Value for the interrupt-enable flag |
| tpa | output | 1 | Early timing strobe |
| tpb | output | 1 | Late timing strobe, which is also the request capture point |
| sc | output | 2 | State code |
| addr_sel_r0 | output | 1 | Take the memory address from register 0 |
| dma_wr | output | 1 | DMA cycle writes memory |
| dma_rd | output | 1 | DMA cycle reads memory |
| ptr_inc | output | 1 | Increment register 0 |
| x_q | output | 4 | X designator |
| p_q | output | 4 | P designator |
| t_q | output | 8 | Save register |
| ie_q | output | 1 | Interrupt enable |

## Verification
The hardest situation to reach is one where the result depends on when a request arrives inside the cycle, rather than on which requests are present. Examples are a short interrupt pulse that lands on the capture clock, one that just misses it, and an interrupt held high across its own entry cycle. The directed tasks first lock onto the `tpa` strobe and then count falling edges within the cycle, so pulses land on chosen phases. A held request competes with a DMA request that is being released one cycle at a time, which shows each step of the priority order in turn.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    localparam int DESIG_W = 4;

    localparam logic [DESIG_W-1:0] IRQ_X = DESIG_W'(2);
    localparam logic [DESIG_W-1:0] IRQ_P = DESIG_W'(1);

    typedef enum logic [1:0] {
        ST_FETCH = 2'b00,
        ST_EXEC  = 2'b01,
        ST_DMA   = 2'b10,
        ST_INT   = 2'b11
    } mstate_e;

    typedef struct packed {
        logic dma_in;
        logic dma_out;
        logic irq;
    } req_s;

    typedef struct packed {
        mstate_e st;
        logic    to_mem;
    } choice_s;

    // fixed-order arbitration: inbound DMA, outbound DMA, interrupt
    function automatic choice_s arbitrate(input req_s r, input logic irq_ok);
        choice_s c;
        if (r.dma_in) begin
            c.st = ST_DMA;   c.to_mem = 1'b1;
        end else if (r.dma_out) begin
            c.st = ST_DMA;   c.to_mem = 1'b0;
        end else if (r.irq && irq_ok) begin
            c.st = ST_INT;   c.to_mem = 1'b0;
        end else begin
            c.st = ST_FETCH; c.to_mem = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/mseq_timing.sv
module mseq_timing #(
    parameter int CYC_LEN = 8,
    parameter int TPA_PH  = 1,
    parameter int TPB_PH  = 5
) (
    input  logic clk,
    input  logic rst,
    output logic tpa,
    output logic tpb,
    output logic cyc_end
);
    localparam int PW = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;
    localparam logic [PW-1:0] LAST_P = PW'(CYC_LEN - 1);
    localparam logic [PW-1:0] TPA_P  = PW'(TPA_PH);
    localparam logic [PW-1:0] TPB_P  = PW'(TPB_PH);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst)                  phase <= '0;
        else if (phase == LAST_P) phase <= '0;
        else                      phase <= phase + 1'b1;
    end

    assign tpa     = (phase == TPA_P);
    assign tpb     = (phase == TPB_P);
    assign cyc_end = (phase == LAST_P);
endmodule

// File: rtl/mseq_reqlatch.sv
module mseq_reqlatch
    import mseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample,
    input  req_s req_in,
    output req_s req_q
);
    always_ff @(posedge clk) begin
        if (rst)         req_q <= '0;
        else if (sample) req_q <= req_in;
    end
endmodule

// File: rtl/mseq_desig.sv
module mseq_desig
    import mseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               int_commit,
    input  logic               xp_wr_en,
    input  logic [DESIG_W-1:0] x_wr,
    input  logic [DESIG_W-1:0] p_wr,
    input  logic               ie_wr_en,
    input  logic               ie_wr_val,
    output logic [DESIG_W-1:0] x_q,
    output logic [DESIG_W-1:0] p_q,
    output logic [2*DESIG_W-1:0] t_q,
    output logic               ie_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            x_q  <= '0;
            p_q  <= '0;
            t_q  <= '0;
            ie_q <= 1'b1;
        end else if (int_commit) begin
            t_q  <= {x_q, p_q};
            x_q  <= IRQ_X;
            p_q  <= IRQ_P;
            ie_q <= 1'b0;
        end else begin
            if (xp_wr_en) begin
                x_q <= x_wr;
                p_q <= p_wr;
            end
            if (ie_wr_en) ie_q <= ie_wr_val;
        end
    end
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
    import mseq_pkg::*;
#(
    parameter int CYC_LEN = 8,
    parameter int TPA_PH  = 1,
    parameter int TPB_PH  = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       dma_in_req,
    input  logic       dma_out_req,
    input  logic       irq_req,
    input  logic       exec_done,
    input  logic       xp_wr_en,
    input  logic [3:0] x_wr,
    input  logic [3:0] p_wr,
    input  logic       ie_wr_en,
    input  logic       ie_wr_val,
    output logic       tpa,
    output logic       tpb,
    output logic [1:0] sc,
    output logic       addr_sel_r0,
    output logic       dma_wr,
    output logic       dma_rd,
    output logic       ptr_inc,
    output logic [3:0] x_q,
    output logic [3:0] p_q,
    output logic [7:0] t_q,
    output logic       ie_q
);
    logic    cyc_end;
    req_s    req_now, req_q;
    mstate_e st;
    logic    to_mem;
    choice_s pick;
    logic    int_commit;

    mseq_timing #(.CYC_LEN(CYC_LEN), .TPA_PH(TPA_PH), .TPB_PH(TPB_PH)) u_timing (
        .clk(clk), .rst(rst), .tpa(tpa), .tpb(tpb), .cyc_end(cyc_end)
    );

    assign req_now = '{dma_in: dma_in_req, dma_out: dma_out_req, irq: irq_req};

    mseq_reqlatch u_req (
        .clk(clk), .rst(rst), .sample(tpb), .req_in(req_now), .req_q(req_q)
    );

    // an interrupt cycle masks the still-set enable flag for its own decision
    assign pick = arbitrate(req_q, ie_q && (st != ST_INT));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_FETCH;
            to_mem <= 1'b0;
        end else if (cyc_end) begin
            case (st)
                ST_FETCH: begin
                    st     <= ST_EXEC;
                    to_mem <= 1'b0;
                end
                ST_EXEC: begin
                    if (exec_done) begin
                        st     <= pick.st;
                        to_mem <= pick.to_mem;
                    end
                end
                default: begin
                    st     <= pick.st;
                    to_mem <= pick.to_mem;
                end
            endcase
        end
    end

    assign int_commit = cyc_end && (st == ST_INT);

    mseq_desig u_desig (
        .clk(clk), .rst(rst), .int_commit(int_commit),
        .xp_wr_en(xp_wr_en), .x_wr(x_wr), .p_wr(p_wr),
        .ie_wr_en(ie_wr_en), .ie_wr_val(ie_wr_val),
        .x_q(x_q), .p_q(p_q), .t_q(t_q), .ie_q(ie_q)
    );

    assign sc          = st;
    assign addr_sel_r0 = (st == ST_DMA);
    assign dma_wr      = (st == ST_DMA) && to_mem;
    assign dma_rd      = (st == ST_DMA) && !to_mem;
    assign ptr_inc     = cyc_end && (st == ST_DMA);
endmodule

// File: rtl/mseq_sequencer_chk.sv
module mseq_sequencer_chk #(
    parameter int CYC_LEN = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       tpa,
    input logic       tpb,
    input logic [1:0] sc,
    input logic       addr_sel_r0,
    input logic       dma_wr,
    input logic       dma_rd,
    input logic       ptr_inc,
    input logic [3:0] x_q,
    input logic [3:0] p_q,
    input logic       ie_q
);
    localparam int CW = $clog2(CYC_LEN) + 2;
    logic [CW-1:0] int_run;

    always_ff @(posedge clk) begin
        if (rst)               int_run <= '0;
        else if (sc == 2'b11)  int_run <= int_run + 1'b1;
        else                   int_run <= '0;
    end

    assert_strobe_apart_R2: assert property (@(posedge clk) disable iff (rst)
        tpa |-> !tpb);
    assert_code_steady_R2: assert property (@(posedge clk) disable iff (rst)
        tpa |-> $stable(sc));
    assert_fetch_then_exec_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(sc) == 2'b00 && sc != 2'b00) |-> sc == 2'b01);
    assert_no_dma_after_fetch_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(sc) == 2'b00) |-> sc != 2'b10);
    assert_inc_in_dma_R8: assert property (@(posedge clk) disable iff (rst)
        ptr_inc |-> (sc == 2'b10 && addr_sel_r0));
    assert_dir_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        (dma_wr || dma_rd) |-> (addr_sel_r0 && !(dma_wr && dma_rd)));
    assert_int_exit_effects_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(sc) == 2'b11 && sc != 2'b11) |-> (!ie_q && x_q == 4'd2 && p_q == 4'd1));
    assert_int_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
        (sc == 2'b11 && $past(sc) != 2'b11) |-> $past(ie_q));
    assert_single_int_cycle_R12: assert property (@(posedge clk) disable iff (rst)
        (sc == 2'b11) |-> (int_run < CW'(CYC_LEN)));
endmodule

bind mseq_sequencer mseq_sequencer_chk #(.CYC_LEN(CYC_LEN)) u_chk (
    .clk(clk), .rst(rst), .tpa(tpa), .tpb(tpb), .sc(sc),
    .addr_sel_r0(addr_sel_r0), .dma_wr(dma_wr), .dma_rd(dma_rd),
    .ptr_inc(ptr_inc), .x_q(x_q), .p_q(p_q), .ie_q(ie_q)
);

// File: tb/mseq_sequencer_tb.sv
module mseq_sequencer_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dma_in_req = 0, dma_out_req = 0, irq_req = 0, exec_done = 1;
    logic xp_wr_en = 0, ie_wr_en = 0, ie_wr_val = 0;
    logic [3:0] x_wr = 0, p_wr = 0;
    logic tpa, tpb, addr_sel_r0, dma_wr, dma_rd, ptr_inc, ie_q;
    logic [1:0] sc;
    logic [3:0] x_q, p_q;
    logic [7:0] t_q;

    int total = 0;
    int bad = 0;
    int inc_seen = 0;

    always #5 clk = ~clk;

    mseq_sequencer u_dut (
        .clk(clk), .rst(rst), .dma_in_req(dma_in_req), .dma_out_req(dma_out_req),
        .irq_req(irq_req), .exec_done(exec_done), .xp_wr_en(xp_wr_en),
        .x_wr(x_wr), .p_wr(p_wr), .ie_wr_en(ie_wr_en), .ie_wr_val(ie_wr_val),
        .tpa(tpa), .tpb(tpb), .sc(sc), .addr_sel_r0(addr_sel_r0),
        .dma_wr(dma_wr), .dma_rd(dma_rd), .ptr_inc(ptr_inc),
        .x_q(x_q), .p_q(p_q), .t_q(t_q), .ie_q(ie_q)
    );

    always @(negedge clk) if (!rst && ptr_inc) inc_seen++;

    task automatic check_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic to_tpa();
        @(negedge clk);
        while (tpa !== 1'b1) @(negedge clk);
    endtask

    task automatic to_fetch();
        to_tpa();
        while (sc !== 2'b00) to_tpa();
    endtask

    task automatic write_ie(input logic v);
        ie_wr_en = 1; ie_wr_val = v;
        @(negedge clk);
        ie_wr_en = 0;
    endtask

    task automatic t_reset();
        check_eq("R1 sc after reset", sc, 2'b00);
        check_eq("R1 ie after reset", ie_q, 1);
        check_eq("R1 x/p/t after reset", {x_q, p_q, t_q}, 0);
    endtask

    task automatic t_timing();
        int n;
        to_tpa();
        n = 0;
        do begin @(negedge clk); n++; end while (tpb !== 1'b1);
        check_eq("R2 tpa to tpb clocks", n, 4);
        do begin @(negedge clk); n++; end while (tpa !== 1'b1);
        check_eq("R2 cycle length", n, 8);
    endtask

    task automatic t_fetch_exec();
        to_fetch();
        to_tpa(); check_eq("R3 fetch then execute", sc, 2'b01);
        to_tpa(); check_eq("R3 back to fetch", sc, 2'b00);
    endtask

    task automatic t_long_exec_dma();
        int base;
        to_fetch();
        exec_done = 0; dma_in_req = 1;
        base = inc_seen;
        to_tpa(); check_eq("R7 execute before dma", sc, 2'b01);
        to_tpa(); check_eq("R4 long execute repeats", sc, 2'b01);
        exec_done = 1;
        to_tpa(); check_eq("R7 dma after done", sc, 2'b10);
        check_eq("R8 inbound dir", {addr_sel_r0, dma_wr, dma_rd}, 3'b110);
        to_tpa(); check_eq("R9 dma repeats", sc, 2'b10);
        dma_in_req = 0;
        to_tpa(); check_eq("R9 dma ends to fetch", sc, 2'b00);
        check_eq("R8 one inc per dma cycle", inc_seen - base, 2);
    endtask

    task automatic t_interrupt();
        to_fetch();
        xp_wr_en = 1; x_wr = 4'd5; p_wr = 4'd3;
        @(negedge clk);
        xp_wr_en = 0; irq_req = 1;
        to_tpa(); check_eq("R11 exec before int", sc, 2'b01);
        to_tpa(); check_eq("R10 int cycle", sc, 2'b11);
        check_eq("R10 x unchanged inside int", x_q, 4'd5);
        to_tpa(); check_eq("R12 int then fetch", sc, 2'b00);
        check_eq("R10 t saved", t_q, 8'h53);
        check_eq("R10 x/p/ie forced", {x_q, p_q, 3'b000, ie_q}, 12'h210);
        to_tpa(); check_eq("R11 exec", sc, 2'b01);
        to_tpa(); check_eq("R11 masked irq gives fetch", sc, 2'b00);
        dma_out_req = 1;
        to_tpa();
        to_tpa(); check_eq("R11 dma ignores ie", sc, 2'b10);
        check_eq("R8 outbound dir", {addr_sel_r0, dma_wr, dma_rd}, 3'b101);
        dma_out_req = 0;
        to_tpa(); check_eq("R9 dma ends", sc, 2'b00);
        write_ie(1);
        to_tpa();
        to_tpa(); check_eq("R11 enabled irq taken", sc, 2'b11);
        irq_req = 0;
        to_tpa(); check_eq("R12 back to fetch", sc, 2'b00);
    endtask

    task automatic t_window();
        to_fetch();
        write_ie(1);
        to_tpa();
        irq_req = 1;
        @(negedge clk); @(negedge clk);
        irq_req = 0;
        to_tpa(); check_eq("R5 early pulse ignored", sc, 2'b00);
        check_eq("R5 ie untouched", ie_q, 1);
        to_tpa();
        while (tpb !== 1'b1) @(negedge clk);
        irq_req = 1;
        @(negedge clk);
        irq_req = 0;
        to_tpa(); check_eq("R5 pulse on tpb taken", sc, 2'b11);
    endtask

    task automatic t_priority();
        to_fetch();
        write_ie(1);
        dma_in_req = 1; dma_out_req = 1; irq_req = 1;
        to_tpa(); check_eq("R6 exec first", sc, 2'b01);
        to_tpa(); check_eq("R6 inbound wins", {sc, dma_wr}, 3'b101);
        dma_in_req = 0;
        to_tpa(); check_eq("R6 outbound next", {sc, dma_rd}, 3'b101);
        dma_out_req = 0;
        to_tpa(); check_eq("R6 interrupt last", sc, 2'b11);
        to_tpa(); check_eq("R12 no second int", sc, 2'b00);
        irq_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_reset();
        t_timing();
        t_fetch_exec();
        t_long_exec_dma();
        t_interrupt();
        t_window();
        t_priority();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule